// File: doc/BRIEF.md
# Cascadable LCD Segment Column Loader

This block takes display data for one row of a 240-column segment driver, a few bits at a time, from a parallel bus that is 4 or 8 bits wide. Each falling edge of the data shift clock writes one bus word into a row-wide input latch. A one-hot pointer picks the columns that the word lands in. Several devices can share one bus. An enable token passes from one device to the next, so that only the device that holds the token takes data. When a device has filled its last column group, it hands the token on to its neighbour. A direction select sets which way the columns are filled. It also sets which enable pin receives the token and which one passes it on.

On a falling edge of the row clock, the whole input latch is copied into an output latch, and the block re-arms to wait for the token again. Every column of the output latch, together with the frame alternation signal, produces a 2-bit selector that names one of four drive levels. A display-off input blanks all columns. The analog level shifting and the high-voltage drive are outside this block; it delivers only the level selector.

The two clocks are sampled by the core clock `clk`. An edge is seen when a clock line was high at one `clk` edge and is low at the next one.

Top module: `lcdseg_loader`

## Requirements
- R1: The block has 240 columns. Column c drives its own 2-bit level selector on `level_code[2c+1:2c]`.
- R2: With `bus_wide`=1, each accepted shift edge writes 8 columns, and `data_in[j]` goes to the j-th column of the group. With `bus_wide`=0, `data_in[3:0]` writes 4 columns and `data_in[7:4]` is unused.
- R3: The pointer moves only on a shift-clock falling edge. A full row takes 30 accepted edges in 8-bit mode and 60 in 4-bit mode.
- R4: The output latch takes the whole input latch on a row-clock falling edge and keeps its value at all other times. That same edge re-arms the block to wait for the token.
- R5: The level selector is {~bit, alt}: 00 (V1) for data 1 with alt 0, 01 (V2) for data 1 with alt 1, 10 (V3) for data 0 with alt 0, and 11 (V4) for data 0 with alt 1.
- R6: With `dir_rev`=0, logical column k is physical column k, the token comes in on `en_a_i` and leaves on `en_b_o` (`en_b_oe`=1, `en_a_oe`=0). With `dir_rev`=1, logical column k is physical column 239-k, the token comes in on `en_b_i` and leaves on `en_a_o` (`en_a_oe`=1, `en_b_oe`=0).
- R7: While the block waits, a shift edge with the incoming enable low is ignored. The first edge with the incoming enable high writes the first column group.
- R8: After the last group is written, the outgoing enable is high until the next shift falling edge. After that, shift edges are ignored until a row-clock falling edge.
- R9: A synchronous active-low reset clears both latches, empties the pointer and puts the block in the waiting state. No edge is seen in the first cycle after reset.
- R10: With `disp_on`=0, every column reads 00 (V1), whatever the latched data and `alt` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wide | input | 1 | 1: 8-bit words, 0: 4-bit words |
| dir_rev | input | 1 | Fill direction and role of the enable pins |
| data_in | input | 8 | Display data word |
| shift_clk | input | 1 | Data shift clock, acts on its falling edge |
| row_clk | input | 1 | Row clock, acts on its falling edge |
| alt | input | 1 | Frame alternation signal |
| disp_on | input | 1 | Low blanks all columns |
| en_a_i | input | 1 | Enable pin A, incoming value |
| en_a_o | output | 1 | Enable pin A, outgoing value |
| en_a_oe | output | 1 | Enable pin A drives when high |
| en_b_i | input | 1 | Enable pin B, incoming value |
| en_b_o | output | 1 | Enable pin B, outgoing value |
| en_b_oe | output | 1 | Enable pin B drives when high |
| level_code | output | 480 | Level selectors, 2 bits per column |

## Verification
The bench loads whole rows in the forward direction with 8-bit words and in the reverse direction with 4-bit words. Every word differs from its neighbours, so a word written to the wrong group, a mirrored or swapped nibble, or a wrong pointer step all show up as wrong columns. Shift edges sent before the token arrives, and edges sent after the row is full, test whether the block ignores them as it should. A row clock sent in the middle of a row shows that the block re-arms. Toggling `alt` and `disp_on` over latched data that holds both 0 and 1 columns covers all four level codes and the blanking override.

// File: rtl/lcdseg_pkg.sv
`timescale 1ns/1ps
// Shared types and level-selector codes for the segment column loader.
package lcdseg_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,   // waiting for the incoming enable token
        ST_LOAD = 2'd1,   // taking words, pointer running
        ST_PASS = 2'd2,   // row full, outgoing enable asserted
        ST_DONE = 2'd3    // row full, shift edges ignored
    } ld_state_t;

    localparam logic [1:0] LVL_V1 = 2'b00;
    localparam logic [1:0] LVL_V2 = 2'b01;
    localparam logic [1:0] LVL_V3 = 2'b10;
    localparam logic [1:0] LVL_V4 = 2'b11;
endpackage

// File: rtl/lcdseg_ptr.sv
`timescale 1ns/1ps
// One-hot write pointer and token state machine.
// Each stage covers one nibble group of columns. In wide mode a write
// covers two stages, so the pointer steps by two.
// Assumes: STAGES is even; edge strobes last one clk cycle.
module lcdseg_ptr
    import lcdseg_pkg::*;
#(
    parameter int STAGES = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_fall,
    input  logic              row_fall,
    input  logic              wide,
    input  logic              tok_in,
    output logic [STAGES-1:0] wr_stage,
    output logic              tok_out
);
    ld_state_t         state;
    logic [STAGES-1:0] ptr;
    logic [STAGES-1:0] eff;
    logic [STAGES-1:0] nxt;
    logic              take;
    logic              last;

    // Effective position: a waiting block implicitly points at stage 0.
    always_comb begin
        eff = (state == ST_WAIT) ? {{(STAGES-1){1'b0}}, 1'b1} : ptr;
        nxt = wide ? (eff << 2) : (eff << 1);
        last = wide ? eff[STAGES-2] : eff[STAGES-1];
        take = shift_fall && !row_fall &&
               ((state == ST_WAIT && tok_in) || state == ST_LOAD);
    end

    // Stage write strobes: one stage, or a pair of stages in wide mode.
    always_comb begin
        wr_stage = '0;
        if (take) begin
            wr_stage = eff | (wide ? {eff[STAGES-2:0], 1'b0} : '0);
        end
    end

    // State and pointer update on shift and row edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            ptr   <= '0;
        end else if (row_fall) begin
            state <= ST_WAIT;
            ptr   <= '0;
        end else if (shift_fall) begin
            case (state)
                ST_WAIT, ST_LOAD: begin
                    if (take) begin
                        if (last) begin
                            state <= ST_PASS;
                            ptr   <= '0;
                        end else begin
                            state <= ST_LOAD;
                            ptr   <= nxt;
                        end
                    end
                end
                ST_PASS: state <= ST_DONE;
                default: state <= ST_DONE;
            endcase
        end
    end

    // Outgoing token level.
    assign tok_out = (state == ST_PASS);

    AST_PTR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr)); // R3
    AST_PASS_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_out && shift_fall && !row_fall) |=> !tok_out); // R8
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        row_fall |=> (state == ST_WAIT && ptr == '0)); // R4
endmodule

// File: rtl/lcdseg_latch.sv
`timescale 1ns/1ps
// Row-wide input latch with direction mirroring, and the output latch.
// Physical column p takes logical column p (forward) or COLS-1-p (reverse).
// Assumes: COLS divisible by 2*NIB.
module lcdseg_latch #(
    parameter int COLS = 240,
    parameter int NIB  = 4,
    localparam int STG = COLS / NIB,
    localparam int BUS = 2 * NIB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [STG-1:0]  wr_stage,
    input  logic            wide,
    input  logic            rev,
    input  logic [BUS-1:0]  data,
    input  logic            row_fall,
    output logic [COLS-1:0] out_bits
);
    logic [COLS-1:0] in_q;
    logic [COLS-1:0] wr_col;
    logic [COLS-1:0] wbit;

    // Per-column write strobe and data bit, chosen by direction.
    for (genvar p = 0; p < COLS; p++) begin : g_col
        localparam int FS = p / NIB;
        localparam int FB = p % NIB;
        localparam int RS = (COLS - 1 - p) / NIB;
        localparam int RB = (COLS - 1 - p) % NIB;
        logic bit_f;
        logic bit_r;
        if (FS % 2 == 1) begin : g_fhi
            assign bit_f = wide ? data[NIB+FB] : data[FB];
        end else begin : g_flo
            assign bit_f = data[FB];
        end
        if (RS % 2 == 1) begin : g_rhi
            assign bit_r = wide ? data[NIB+RB] : data[RB];
        end else begin : g_rlo
            assign bit_r = data[RB];
        end
        assign wr_col[p] = rev ? wr_stage[RS] : wr_stage[FS];
        assign wbit[p]   = rev ? bit_r : bit_f;
    end

    // Input latch: strobed columns take new data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q <= '0;
        end else begin
            in_q <= (in_q & ~wr_col) | (wbit & wr_col);
        end
    end

    // Output latch: whole-row copy on the row edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bits <= '0;
        end else if (row_fall) begin
            out_bits <= in_q;
        end
    end

    AST_INPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stage == '0) |=> $stable(in_q)); // R7
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !row_fall |=> $stable(out_bits)); // R4
endmodule

// File: rtl/lcdseg_level.sv
`timescale 1ns/1ps
// Per-column drive-level selector from latched bit and alternation.
// Assumes: codes follow lcdseg_pkg LVL_* encoding.
module lcdseg_level
    import lcdseg_pkg::*;
#(
    parameter int COLS = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COLS-1:0]   bits,
    input  logic              alt,
    input  logic              disp_on,
    output logic [2*COLS-1:0] codes
);
    // One selector per column; blanking overrides data.
    for (genvar p = 0; p < COLS; p++) begin : g_lvl
        assign codes[2*p +: 2] = disp_on ? {~bits[p], alt} : LVL_V1;
    end

    AST_ALT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        disp_on |-> (codes[0] == alt)); // R5
endmodule

// File: rtl/lcdseg_loader.sv
`timescale 1ns/1ps
// Top: cascadable segment column loader.
// Samples the shift and row clocks with clk and acts on falling edges.
// Assumes: shift and row clock levels each last at least one clk cycle.
module lcdseg_loader #(
    parameter int COLS = 240,
    parameter int NIB  = 4,
    localparam int STG = COLS / NIB,
    localparam int BUS = 2 * NIB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wide,
    input  logic              dir_rev,
    input  logic [BUS-1:0]    data_in,
    input  logic              shift_clk,
    input  logic              row_clk,
    input  logic              alt,
    input  logic              disp_on,
    input  logic              en_a_i,
    output logic              en_a_o,
    output logic              en_a_oe,
    input  logic              en_b_i,
    output logic              en_b_o,
    output logic              en_b_oe,
    output logic [2*COLS-1:0] level_code
);
    logic            shift_q;
    logic            row_q;
    logic            shift_fall;
    logic            row_fall;
    logic            tok_in;
    logic            tok_out;
    logic [STG-1:0]  wr_stage;
    logic [COLS-1:0] out_bits;

    // Previous clock-line samples for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= 1'b0;
            row_q   <= 1'b0;
        end else begin
            shift_q <= shift_clk;
            row_q   <= row_clk;
        end
    end

    // Falling edges and token pin routing.
    always_comb begin
        shift_fall = shift_q && !shift_clk;
        row_fall   = row_q && !row_clk;
        tok_in     = dir_rev ? en_b_i : en_a_i;
        en_a_oe    = dir_rev;
        en_b_oe    = !dir_rev;
        en_a_o     = dir_rev && tok_out;
        en_b_o     = !dir_rev && tok_out;
    end

    lcdseg_ptr #(.STAGES(STG)) u_ptr (
        .clk(clk), .rst_n(rst_n), .shift_fall(shift_fall), .row_fall(row_fall),
        .wide(bus_wide), .tok_in(tok_in), .wr_stage(wr_stage), .tok_out(tok_out)
    );

    lcdseg_latch #(.COLS(COLS), .NIB(NIB)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_stage(wr_stage), .wide(bus_wide),
        .rev(dir_rev), .data(data_in), .row_fall(row_fall), .out_bits(out_bits)
    );

    lcdseg_level #(.COLS(COLS)) u_level (
        .clk(clk), .rst_n(rst_n), .bits(out_bits), .alt(alt),
        .disp_on(disp_on), .codes(level_code)
    );

    AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_fall |-> (wr_stage == '0)); // R3
endmodule

// File: tb/test_lcdseg_loader.sv
`timescale 1ns/1ps
// Bench: behavioural row model compared with the design on every clock.
module test_lcdseg_loader;
    localparam int COLS = 240;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wide = 1'b1, dir_rev = 1'b0;
    logic [7:0] data_in = '0;
    logic shift_clk = 1'b0, row_clk = 1'b0, alt = 1'b0, disp_on = 1'b1;
    logic en_a_i = 1'b0, en_b_i = 1'b0;
    logic en_a_o, en_a_oe, en_b_o, en_b_oe;
    logic [2*COLS-1:0] level_code;

    int checks = 0, errors = 0;
    string tag = "R9";
    bit finished = 0;

    // Reference state
    bit m_in[COLS];
    bit m_out[COLS];
    int m_st = 0;   // 0 wait, 1 load, 2 pass, 3 done
    int m_pos = 0;
    bit m_p2 = 0, m_p1 = 0;

    always #2.5 clk = ~clk;

    lcdseg_loader i_lcdseg_loader (
        .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .dir_rev(dir_rev),
        .data_in(data_in), .shift_clk(shift_clk), .row_clk(row_clk),
        .alt(alt), .disp_on(disp_on), .en_a_i(en_a_i), .en_a_o(en_a_o),
        .en_a_oe(en_a_oe), .en_b_i(en_b_i), .en_b_o(en_b_o),
        .en_b_oe(en_b_oe), .level_code(level_code)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_write();
        int w = bus_wide ? 8 : 4;
        for (int j = 0; j < w; j++) begin
            int c = m_pos + j;
            int p = dir_rev ? COLS - 1 - c : c;
            m_in[p] = data_in[j];
        end
        m_pos += w;
        m_st = (m_pos == COLS) ? 2 : 1;
    endtask

    task automatic model_update();
        bit f2, f1, tin;
        if (!rst_n) begin
            for (int c = 0; c < COLS; c++) begin m_in[c] = 0; m_out[c] = 0; end
            m_st = 0; m_pos = 0; m_p2 = 0; m_p1 = 0;
        end else begin
            f2 = m_p2 && !shift_clk;
            f1 = m_p1 && !row_clk;
            tin = dir_rev ? en_b_i : en_a_i;
            if (f1) begin
                for (int c = 0; c < COLS; c++) m_out[c] = m_in[c];
                m_st = 0; m_pos = 0;
            end else if (f2) begin
                case (m_st)
                    0: if (tin) model_write();
                    1: model_write();
                    2: m_st = 3;
                    default: m_st = 3;
                endcase
            end
            m_p2 = shift_clk;
            m_p1 = row_clk;
        end
    endtask

    task automatic compare();
        int bad = -1;
        logic [1:0] e, a;
        bit tok;
        for (int c = 0; c < COLS; c++) begin
            e = disp_on ? {~m_out[c], alt} : 2'b00;
            a = level_code[2*c +: 2];
            if (a !== e && bad < 0) bad = c;
        end
        if (bad >= 0) begin
            e = disp_on ? {~m_out[bad], alt} : 2'b00;
            chk(0, tag, $sformatf("level col %0d", bad),
                int'(level_code[2*bad +: 2]), int'(e));
        end else chk(1, tag, "level", 0, 0);
        tok = (m_st == 2);
        chk({en_a_oe, en_b_oe, en_a_o, en_b_o} ===
            {dir_rev, !dir_rev, dir_rev & tok, !dir_rev & tok},
            tag, "enable pins (R6 R8)",
            int'({en_a_oe, en_b_oe, en_a_o, en_b_o}),
            int'({dir_rev, !dir_rev, dir_rev & tok, !dir_rev & tok}));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare();
    endtask

    task automatic shift_word(input logic [7:0] d);
        shift_clk = 1'b1; step();
        data_in = d; shift_clk = 1'b0; step();
    endtask

    task automatic row_pulse();
        row_clk = 1'b1; step();
        row_clk = 1'b0; step();
    endtask

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) ^ (k << 3));
    endfunction

    initial begin
        @(posedge clk); #1;
        // R9: reset clears latches (all columns data 0 -> V3 code with alt 0)
        tag = "R9";
        repeat (3) step();
        rst_n = 1'b1;
        step(); step();
        chk(level_code[1:0] === 2'b10, "R9", "col0 after reset", int'(level_code[1:0]), 2);

        // R7: shift edges without the token are ignored
        tag = "R7";
        bus_wide = 1'b1; dir_rev = 1'b0; en_a_i = 1'b0;
        for (int k = 0; k < 3; k++) shift_word(8'hFF);
        row_pulse();
        chk(level_code[1:0] === 2'b10, "R7", "no write before token", int'(level_code[1:0]), 2);

        // R2 R1 R6: forward 8-bit row
        tag = "R2";
        for (int k = 0; k < 30; k++) begin
            en_a_i = (k == 0);
            shift_word(pat(k));
            // R3: outgoing enable only after the 30th word
            if (k == 28) chk(en_b_o === 1'b0, "R3", "no token after 29 words", int'(en_b_o), 0);
            if (k == 29) chk(en_b_o === 1'b1, "R3", "token after 30 words", int'(en_b_o), 1);
        end
        // R8: token drops on next edge; later edges ignored
        tag = "R8";
        shift_word(8'h00);
        chk(en_b_o === 1'b0, "R8", "token dropped", int'(en_b_o), 0);
        shift_word(8'h00);
        // R4: copy on row edge
        tag = "R4";
        row_pulse();
        chk(level_code[1:0] === {~pat(0)[0], 1'b0}, "R4", "col0 after copy",
            int'(level_code[1:0]), int'({~pat(0)[0], 1'b0}));
        chk(level_code[2*239 +: 2] === {~pat(29)[7], 1'b0}, "R1", "col239 after copy",
            int'(level_code[2*239 +: 2]), int'({~pat(29)[7], 1'b0}));

        // R5 and R10: alternation and blanking
        tag = "R5";
        alt = 1'b1; step(); step();
        tag = "R10";
        disp_on = 1'b0; step(); step();
        chk(level_code === '0, "R10", "blank all V1", 0, 0);
        disp_on = 1'b1; alt = 1'b0;

        // R6 R3: reverse 4-bit row
        tag = "R6";
        bus_wide = 1'b0; dir_rev = 1'b1; en_a_i = 1'b0; step();
        for (int k = 0; k < 60; k++) begin
            en_b_i = (k == 0);
            shift_word(pat(k + 5) | 8'hF0);
            if (k == 58) chk(en_a_o === 1'b0, "R3", "no token after 59 nibbles", int'(en_a_o), 0);
            if (k == 59) chk(en_a_o === 1'b1, "R6", "token on pin A", int'(en_a_o), 1);
        end
        tag = "R4";
        row_pulse();
        chk(level_code[2*239 +: 2] === {~pat(5)[0], 1'b0}, "R6", "col239 holds first bit",
            int'(level_code[2*239 +: 2]), int'({~pat(5)[0], 1'b0}));

        // R8 R4: row edge mid-row re-arms; edges without token ignored
        tag = "R8";
        for (int k = 0; k < 10; k++) begin
            en_b_i = (k == 0);
            shift_word(8'h05);
        end
        row_pulse();
        for (int k = 0; k < 4; k++) shift_word(8'h0A);
        row_pulse();
        alt = 1'b1; step();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule